// File: doc/BRIEF.md
# Radix-3 Trit Selection Tree

This block picks one trit out of a bank of 3^n trits, steered by n select trits. Each trit travels on two wires: 2'b00 means 0, 2'b01 means 1 and 2'b10 means 2. The code 2'b11 is not a valid trit value.

The tree is built from a single three-way cell. A cell passes its input 0, 1 or 2 when its select trit is 0, 1 or 2. The cells are stacked in n levels:

- Select trit 0 steers the widest level, the one that faces the data inputs.
- The most significant select trit steers the single cell at the root.
- With the default of three select trits, the tree has 9 + 3 + 1 = 13 cells. Two select trits give a 9-way tree of four cells, and one select trit gives a single cell.

A select trit that carries 2'b11 forces the result to 0 and raises an error flag.

The result leaves through a valid/ready stream. When the output register is enabled, a request is accepted on a clock edge where in_valid and in_ready are both high. The result, with its error flag, then appears with out_valid on the next cycle. It holds, unchanged, until a clock edge where out_ready is high. in_ready is high whenever the output stage is empty or is being drained in that same cycle, so one result can be accepted every cycle with no bubble. When the output register is disabled, the block is combinational and the handshake wires pass straight through.

Top module: `ttree_mux`

## Requirements
- R1: With all select trits legal, the output trit equals data trit i, where i = sum of S_k·3^k. Data trit i sits on data_in[2i+1:2i]. Select trit k sits on sel_in[2k+1:2k]. The trit codes are 00 = 0, 01 = 1 and 10 = 2.
- R2: With SEL_TRITS = 2, select trit 1 is the more significant digit. S1 = 1 with S0 = 2 returns data trit 5.
- R3: If any select trit carries 2'b11, the result trit is 2'b00 and out_err is 1.
- R4: If every select trit is legal, out_err is 0.
- R5: The selected data trit is passed bit for bit, including the code 2'b11 on a data trit.
- R6: While rst_n is low and on the first cycle after it, out_valid is 0.
- R7: With REG_OUT = 1, in_ready is high when out_valid is low or out_ready is high. An accepted request shows out_valid on the next cycle.
- R8: While out_valid is high and out_ready is low, out_valid, out_trit and out_err stay unchanged.
- R9: With REG_OUT = 0, the result appears in the same cycle as the request. out_valid follows in_valid, and in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A request is presented |
| in_ready | output | 1 | The block can take a request |
| data_in | input | 2·3^SEL_TRITS | Data trits, trit i at bits 2i+1:2i |
| sel_in | input | 2·SEL_TRITS | Select trits, trit k at bits 2k+1:2k |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the result |
| out_trit | output | 2 | Selected trit |
| out_err | output | 1 | An illegal select code was seen |

## Verification
The bench sweeps every select combination twice over random data: once with the output always drained and once under random back-pressure. A tree that wires its levels in the wrong digit order returns the trit at the digit-reversed index, and index 5 of the 9-way tree exposes the same mistake. Illegal codes are placed on each select position in turn; a design that checks only the root level would leak data when the illegal code sits on the low digit. During stalls the bench checks that the held result does not move, which catches a register that reloads while its result is still waiting to be taken.

// File: rtl/ttree_pkg.sv
`timescale 1ns/1ps
package ttree_pkg;
  typedef logic [1:0] trit_t;

  localparam trit_t TRIT_0   = 2'b00;
  localparam trit_t TRIT_1   = 2'b01;
  localparam trit_t TRIT_2   = 2'b10;
  localparam trit_t TRIT_BAD = 2'b11;

  function automatic int unsigned pow3(input int unsigned n);
    int unsigned r;
    r = 1;
    for (int unsigned i = 0; i < n; i++) r = r * 3;
    return r;
  endfunction
endpackage

// File: rtl/ttree_cell.sv
`timescale 1ns/1ps
module ttree_cell
  import ttree_pkg::*;
(
  input  trit_t d0,
  input  trit_t d1,
  input  trit_t d2,
  input  trit_t sel,
  output trit_t y,
  output logic  bad
);
  always_comb begin
    bad = 1'b0;
    unique case (sel)
      TRIT_0:  y = d0;
      TRIT_1:  y = d1;
      TRIT_2:  y = d2;
      default: begin
        y   = TRIT_0;
        bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ttree_level.sv
`timescale 1ns/1ps
module ttree_level
  import ttree_pkg::*;
#(
  parameter int unsigned CELLS = 1
) (
  input  logic [6*CELLS-1:0] din,
  input  trit_t              sel,
  output logic [2*CELLS-1:0] dout,
  output logic               bad
);
  logic [CELLS-1:0] cell_bad;

  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    ttree_cell u_cell (
      .d0  (din[6*c   +: 2]),
      .d1  (din[6*c+2 +: 2]),
      .d2  (din[6*c+4 +: 2]),
      .sel (sel),
      .y   (dout[2*c +: 2]),
      .bad (cell_bad[c])
    );
  end

  assign bad = |cell_bad;
endmodule

// File: rtl/ttree_ostage.sv
`timescale 1ns/1ps
module ttree_ostage
  import ttree_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  trit_t res_trit,
  input  logic  res_err,
  output logic  out_valid,
  input  logic  out_ready,
  output trit_t out_trit,
  output logic  out_err
);
  if (REG_OUT) begin : g_reg
    logic  vld_q;
    trit_t trit_q;
    logic  err_q;

    assign in_ready = !vld_q || out_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        trit_q <= TRIT_0;
        err_q  <= 1'b0;
      end else if (in_ready) begin
        vld_q <= in_valid;
        if (in_valid) begin
          trit_q <= res_trit;
          err_q  <= res_err;
        end
      end
    end

    assign out_valid = vld_q;
    assign out_trit  = trit_q;
    assign out_err   = err_q;
  end else begin : g_pass
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_trit  = res_trit;
    assign out_err   = res_err;
  end
endmodule

// File: rtl/ttree_mux.sv
`timescale 1ns/1ps
module ttree_mux
  import ttree_pkg::*;
#(
  parameter int unsigned SEL_TRITS = 3,
  parameter bit          REG_OUT   = 1'b1,
  localparam int unsigned NUM_IN   = pow3(SEL_TRITS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [2*NUM_IN-1:0]    data_in,
  input  logic [2*SEL_TRITS-1:0] sel_in,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [1:0]             out_trit,
  output logic                   out_err
);
  logic [SEL_TRITS-1:0] lvl_bad;
  trit_t                tree_trit;

  for (genvar k = 0; k < SEL_TRITS; k++) begin : g_lvl
    localparam int unsigned CELLS = pow3(SEL_TRITS - 1 - k);
    logic [2*CELLS-1:0] y;
    logic               bad;

    if (k == 0) begin : g_first
      ttree_level #(.CELLS(CELLS)) u_level (
        .din  (data_in),
        .sel  (sel_in[2*k +: 2]),
        .dout (y),
        .bad  (bad)
      );
    end else begin : g_next
      ttree_level #(.CELLS(CELLS)) u_level (
        .din  (g_lvl[k-1].y),
        .sel  (sel_in[2*k +: 2]),
        .dout (y),
        .bad  (bad)
      );
    end

    assign lvl_bad[k] = bad;
  end

  assign tree_trit = g_lvl[SEL_TRITS-1].y;

  ttree_ostage #(.REG_OUT(REG_OUT)) u_ostage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .res_trit  (tree_trit),
    .res_err   (|lvl_bad),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_trit  (out_trit),
    .out_err   (out_err)
  );
endmodule

// File: rtl/ttree_mux_chk.sv
`timescale 1ns/1ps
module ttree_mux_chk
  import ttree_pkg::*;
#(
  parameter int unsigned SEL_TRITS = 3,
  parameter bit          REG_OUT   = 1'b1,
  localparam int unsigned NUM_IN   = pow3(SEL_TRITS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic [2*NUM_IN-1:0]    data_in,
  input logic [2*SEL_TRITS-1:0] sel_in,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [1:0]             out_trit,
  input logic                   out_err
);
  logic sel_has_bad;
  always_comb begin
    sel_has_bad = 1'b0;
    for (int k = 0; k < int'(SEL_TRITS); k++)
      if (sel_in[2*k +: 2] == TRIT_BAD) sel_has_bad = 1'b1;
  end

  if (REG_OUT) begin : g_reg_chk
    assert_reset_idle_R6: assert property (@(posedge clk)
      !rst_n |=> !out_valid);

    assert_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_trit) && $stable(out_err)));

    assert_stall_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

    assert_err_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (out_err == $past(sel_has_bad)));

    assert_err_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_err) |-> (out_trit == TRIT_0));
  end else begin : g_pass_chk
    assert_pass_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> out_valid);

    assert_pass_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_has_bad |-> !out_err);
  end
endmodule

bind ttree_mux ttree_mux_chk #(.SEL_TRITS(SEL_TRITS), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/tb_ttree_mux.sv
`timescale 1ns/1ps
module tb_ttree_mux;
  localparam int ST  = 3;
  localparam int NI  = 27;
  localparam int ST2 = 2;
  localparam int NI2 = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [2*NI-1:0] data_in = '0;
  logic [2*ST-1:0] sel_in = '0;
  logic            out_valid;
  logic            out_ready = 1'b1;
  logic [1:0]      out_trit;
  logic            out_err;

  ttree_mux #(.SEL_TRITS(ST), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .data_in(data_in), .sel_in(sel_in), .out_valid(out_valid),
    .out_ready(out_ready), .out_trit(out_trit), .out_err(out_err));

  logic             c_valid = 1'b0;
  logic             c_ready_o;
  logic [2*NI2-1:0] c_data = '0;
  logic [2*ST2-1:0] c_sel = '0;
  logic             c_out_valid;
  logic             c_oready = 1'b0;
  logic [1:0]       c_trit;
  logic             c_err;

  ttree_mux #(.SEL_TRITS(ST2), .REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(c_valid), .in_ready(c_ready_o),
    .data_in(c_data), .sel_in(c_sel), .out_valid(c_out_valid),
    .out_ready(c_oready), .out_trit(c_trit), .out_err(c_err));

  int n_checks = 0;
  int n_fail = 0;
  logic [2:0] exp_q[$];
  logic bp_en = 1'b0;
  logic done = 1'b0;

  function automatic logic [2:0] model(input logic [2*NI-1:0] d, input logic [2*ST-1:0] s,
                                       input int nt);
    int idx = 0;
    int w = 1;
    for (int k = 0; k < nt; k++) begin
      if (s[2*k +: 2] == 2'b11) return 3'b100;
      idx = idx + w * int'(s[2*k +: 2]);
      w = w * 3;
    end
    return {1'b0, d[2*idx +: 2]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2*NI-1:0] d, input logic [2*ST-1:0] s);
    logic ok;
    @(negedge clk);
    in_valid = 1'b1;
    data_in  = d;
    sel_in   = s;
    forever begin
      #2;
      ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    exp_q.push_back(model(d, s, ST));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(negedge clk) out_ready = bp_en ? ($urandom % 3 != 0) : 1'b1;

  initial begin : monitor
    logic       stall_prev;
    logic [2:0] held;
    logic [2:0] e;
    stall_prev = 1'b0;
    held = '0;
    forever begin
      @(negedge clk);
      #3;
      if (!rst_n) begin
        stall_prev = 1'b0;
      end else begin
        if (stall_prev) begin
          check("R8 valid held", {31'd0, out_valid}, 32'd1);
          check("R8 result held", {29'd0, out_err, out_trit}, {29'd0, held});
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            check("R7 unexpected result", 32'd1, 32'd0);
          end else begin
            e = exp_q.pop_front();
            if (e[2]) check("R3 illegal select", {29'd0, out_err, out_trit}, {29'd0, e});
            else      check("R1 R4 R5 selected trit", {29'd0, out_err, out_trit}, {29'd0, e});
          end
        end
        stall_prev = out_valid && !out_ready;
        held = {out_err, out_trit};
      end
    end
  end

  initial begin : watchdog
    #(20 * 100000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [2*NI-1:0]  d;
    logic [2*ST-1:0]  s;
    logic [2*NI2-1:0] cd;
    repeat (3) @(posedge clk);
    #5;
    check("R6 out_valid in reset", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #3;
    check("R6 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R7 in_ready when empty", {31'd0, in_ready}, 32'd1);

    // Full sweep of legal selects, no back-pressure (R1, R5)
    for (int i = 0; i < NI; i++) begin
      d = {$urandom, $urandom};
      s = {2'(i / 9), 2'((i / 3) % 3), 2'(i % 3)};
      send(d, s);
    end
    // Same sweep under random back-pressure (R7, R8)
    bp_en = 1'b1;
    for (int i = 0; i < NI; i++) begin
      d = {$urandom, $urandom};
      s = {2'(i / 9), 2'((i / 3) % 3), 2'(i % 3)};
      send(d, s);
    end
    // Illegal code on each select position (R3)
    for (int k = 0; k < ST; k++) begin
      for (int r = 0; r < 4; r++) begin
        d = {$urandom, $urandom};
        s = {2'($urandom % 3), 2'($urandom % 3), 2'($urandom % 3)};
        s[2*k +: 2] = 2'b11;
        send(d, s);
      end
    end
    // Random mix, legal and illegal
    for (int r = 0; r < 40; r++) begin
      d = {$urandom, $urandom};
      s = 6'($urandom);
      send(d, s);
    end
    bp_en = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);

    // Combinational 9-way variant (R2, R9)
    cd = '0;
    cd[11:10] = 2'b10;
    c_data = cd;
    c_sel = {2'b01, 2'b10};
    c_valid = 1'b1;
    c_oready = 1'b0;
    #1;
    check("R2 S1=1 S0=2 picks trit 5", {30'd0, c_trit}, 32'd2);
    check("R9 out_valid follows in_valid", {31'd0, c_out_valid}, 32'd1);
    check("R9 in_ready follows out_ready", {31'd0, c_ready_o}, 32'd0);
    c_oready = 1'b1;
    c_valid = 1'b0;
    #1;
    check("R9 in_ready follows out_ready high", {31'd0, c_ready_o}, 32'd1);
    check("R9 out_valid low", {31'd0, c_out_valid}, 32'd0);
    for (int i = 0; i < NI2; i++) begin
      cd = 18'($urandom);
      c_data = cd;
      c_sel = {2'(i / 3), 2'(i % 3)};
      #1;
      check("R2 9-way selected trit", {29'd0, c_err, c_trit}, {29'd0, 1'b0, cd[2*i +: 2]});
    end
    c_sel = {2'b11, 2'b00};
    #1;
    check("R3 9-way illegal high digit", {29'd0, c_err, c_trit}, 32'd4);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule